// File: doc/BRIEF.md
# SPI Receive Word Packer

This block is the receive side of a serial-peripheral slave. An external host sends words of 8, 16 or 32 bits on a serial clock and data line while it holds the select line low. The block always builds a 32-bit internal word. A narrow host word takes one slot of that word. The first host word received goes into the lowest slot, and each later one goes into the next slot up. When every slot is filled, the finished 32-bit word moves into a one-entry holding register. That register is offered downstream on a valid/ready handshake, which stands in for a memory transfer by a DMA engine.

The serial pins are brought into the system clock domain and sampled on rising serial-clock edges. Each host word arrives most-significant bit first. Bits may arrive with no gap at all between host words or between 32-bit words, which is how a boot image is streamed. The block counts completed handshake transfers. After a fixed boot block of 384 transfers, it raises a done flag. Those 384 transfers hold 256 words of 48-bit instruction storage.

Top module: `spi_rx_packer`

## Requirements
- R1: After a synchronous reset, `word_valid`, `overflow` and `boot_done` are all 0.
- R2: Width code 2'b10, or the spare code 2'b11, selects 32-bit host words. Thirty-two bits, sent MSB first, form one output word.
- R3: Width code 2'b01 selects 16-bit host words. The first host word lands in bits [15:0] and the second in bits [31:16], each sent MSB first.
- R4: Width code 2'b00 selects 8-bit host words. Four host words fill bits [7:0], [15:8], [23:16] and [31:24] in arrival order, each sent MSB first.
- R5: A continuous bit stream with no gaps yields every 32-bit word intact and in order. No bit is lost at host-word or 32-bit boundaries.
- R6: The width code is captured only while `spi_sel_n` is high. A change while select is low has no effect on the word being packed.
- R7: Raising `spi_sel_n` discards any partly received bits and slots. The next frame starts at bit 0 of slot 0.
- R8: `word_data` and `word_valid` stay stable while `word_valid` is 1 and `word_ready` is 0.
- R9: If a word completes while the holding register is full and not being emptied, the new word is dropped and `overflow` becomes 1. It stays 1 until reset.
- R10: `boot_done` rises after the 384th accepted transfer since reset, and not before. Toggling `spi_sel_n` does not clear the transfer count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_sel_n | input | 1 | Active-low slave select |
| width_sel | input | 2 | Host word size: 00=8, 01=16, 10/11=32 |
| word_data | output | 32 | Packed word in the holding register |
| word_valid | output | 1 | Holding register is full |
| word_ready | input | 1 | Downstream accepts the word |
| overflow | output | 1 | Sticky flag for a dropped word |
| boot_done | output | 1 | Boot block of transfers completed |

## Verification
Single words are sent in each width code. The values are asymmetric, so a swapped slot order, a reversed bit order or a wrong slot width each produces a different word. A gapless stream of 8-bit host words covers packing across several 32-bit boundaries. A mid-frame change of the width code shows whether the setting is captured only while deselected. An aborted partial frame shows whether leftover bits leak into the next word. Holding `word_ready` low tests the holding register and the overflow drop. A full 384-word gapless stream, with a deselect just before the last word, tests the exact point at which the done flag rises.

// File: rtl/spi_rx_packer_pkg.sv
package spi_rx_packer_pkg;
  typedef enum logic [1:0] {
    HW_8   = 2'b00,
    HW_16  = 2'b01,
    HW_32  = 2'b10,
    HW_32X = 2'b11
  } host_width_e;
endpackage

// File: rtl/spk_sync.sv
module spk_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spk_packer.sv
module spk_packer
  import spi_rx_packer_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [1:0]        width_in,
  output logic              word_stb,
  output logic [WORD_W-1:0] word_out
);
  localparam int Q_W   = WORD_W / 4;
  localparam int H_W   = WORD_W / 2;
  localparam int CNT_W = $clog2(WORD_W);

  host_width_e       width_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        slot;
  logic [WORD_W-1:0] shreg, pack;
  logic [WORD_W-1:0] sh_next, placed;
  logic [CNT_W-1:0]  last_bit;
  logic [1:0]        last_slot;

  assign sh_next = {shreg[WORD_W-2:0], bit_val};

  always_comb begin
    case (width_q)
      HW_8: begin
        last_bit  = CNT_W'(Q_W - 1);
        last_slot = 2'd3;
        placed    = WORD_W'(sh_next[Q_W-1:0]) << (Q_W * slot);
      end
      HW_16: begin
        last_bit  = CNT_W'(H_W - 1);
        last_slot = 2'd1;
        placed    = WORD_W'(sh_next[H_W-1:0]) << (H_W * slot);
      end
      default: begin
        last_bit  = CNT_W'(WORD_W - 1);
        last_slot = 2'd0;
        placed    = sh_next;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q  <= HW_32;
      bit_cnt  <= '0;
      slot     <= '0;
      shreg    <= '0;
      pack     <= '0;
      word_stb <= 1'b0;
      word_out <= '0;
    end else begin
      word_stb <= 1'b0;
      if (!active) begin
        width_q <= host_width_e'(width_in);
        bit_cnt <= '0;
        slot    <= '0;
        shreg   <= '0;
        pack    <= '0;
      end else if (bit_stb) begin
        if (bit_cnt == last_bit) begin
          bit_cnt <= '0;
          shreg   <= '0;
          if (slot == last_slot) begin
            word_stb <= 1'b1;
            word_out <= pack | placed;
            pack     <= '0;
            slot     <= '0;
          end else begin
            pack <= pack | placed;
            slot <= slot + 2'd1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= sh_next;
        end
      end
    end
  end
endmodule

// File: rtl/spk_hold.sv
module spk_hold #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_stb,
  input  logic [WORD_W-1:0] in_word,
  input  logic              ready,
  output logic [WORD_W-1:0] data,
  output logic              valid,
  output logic              ovf,
  output logic              xfer
);
  assign xfer = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
      ovf   <= 1'b0;
    end else if (in_stb) begin
      if (!valid || ready) begin
        data  <= in_word;
        valid <= 1'b1;
      end else begin
        ovf <= 1'b1;
      end
    end else if (xfer) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spk_boot_cnt.sv
module spk_boot_cnt #(
  parameter int BOOT_WORDS = 384
) (
  input  logic clk,
  input  logic rst,
  input  logic xfer,
  output logic done
);
  localparam int CW = $clog2(BOOT_WORDS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (xfer && !done) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(BOOT_WORDS - 1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_rx_packer.sv
module spi_rx_packer #(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int BOOT_WORDS  = 384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_sel_n,
  input  logic [1:0]        width_sel,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready,
  output logic              overflow,
  output logic              boot_done
);
  logic [2:0]        pins_s;
  logic              sclk_d;
  logic              bit_stb;
  logic              pk_stb;
  logic [WORD_W-1:0] pk_word;
  logic              xfer;

  spk_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_sel_n, spi_mosi, spi_sclk}),
    .dout(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= pins_s[0];
  end

  assign bit_stb = pins_s[0] && !sclk_d;

  spk_packer #(.WORD_W(WORD_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .active  (!pins_s[2]),
    .bit_stb (bit_stb),
    .bit_val (pins_s[1]),
    .width_in(width_sel),
    .word_stb(pk_stb),
    .word_out(pk_word)
  );

  spk_hold #(.WORD_W(WORD_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .in_stb (pk_stb),
    .in_word(pk_word),
    .ready  (word_ready),
    .data   (word_data),
    .valid  (word_valid),
    .ovf    (overflow),
    .xfer   (xfer)
  );

  spk_boot_cnt #(.BOOT_WORDS(BOOT_WORDS)) u_boot (
    .clk (clk),
    .rst (rst),
    .xfer(xfer),
    .done(boot_done)
  );
endmodule

// File: rtl/spi_rx_packer_chk.sv
module spi_rx_packer_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] word_data,
  input logic              word_valid,
  input logic              word_ready,
  input logic              overflow,
  input logic              boot_done
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!word_valid && !overflow && !boot_done));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R9
  overflow_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(word_valid && !word_ready));

  // R10
  boot_done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> boot_done);
endmodule

bind spi_rx_packer spi_rx_packer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_data (word_data),
  .word_valid(word_valid),
  .word_ready(word_ready),
  .overflow  (overflow),
  .boot_done (boot_done)
);

// File: tb/spi_rx_packer_tb.sv
`timescale 1ns/1ps
module spi_rx_packer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, mosi = 1'b0, sel_n = 1'b1, ready = 1'b1;
  logic [1:0] wsel = 2'b10;
  logic [31:0] wdata;
  logic wvalid, ovf, done;

  always #2 clk = ~clk;

  spi_rx_packer u_dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_sel_n(sel_n),
    .width_sel(wsel), .word_data(wdata), .word_valid(wvalid), .word_ready(ready),
    .overflow(ovf), .boot_done(done)
  );

  int checks = 0, errors = 0;
  int rx_total = 0;
  logic [31:0] rx_mem [16];

  always @(negedge clk) begin
    if (!rst && wvalid && ready) begin
      rx_mem[rx_total % 16] = wdata;
      rx_total = rx_total + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0; mosi = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_host(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_word(input logic [1:0] w, input logic [31:0] v);
    if (w == 2'b00)      for (int k = 0; k < 4; k++) send_host({24'h0, v[8*k +: 8]}, 8);
    else if (w == 2'b01) for (int k = 0; k < 2; k++) send_host({16'h0, v[16*k +: 16]}, 16);
    else                 send_host(v, 32);
  endtask

  task automatic sel_on(input logic [1:0] w);
    wsel = w;
    repeat (4) @(negedge clk);
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    sclk = 1'b0;
    repeat (12) @(negedge clk);
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  localparam logic [33:0] VEC [6] = '{
    {2'b10, 32'hDEADBEEF},
    {2'b01, 32'h1234ABCD},
    {2'b00, 32'hA55A0FF0},
    {2'b00, 32'h01020304},
    {2'b11, 32'h80000001},
    {2'b01, 32'hFFFF0000}
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int base;
    logic [31:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'h0, wvalid}, 32'h0);
    chk("R1 overflow", {31'h0, ovf}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);

    // Vector table: R2 (codes 10/11), R3 (code 01), R4 (code 00)
    for (int i = 0; i < 6; i++) begin
      base = rx_total;
      sel_on(VEC[i][33:32]);
      send_word(VEC[i][33:32], VEC[i][31:0]);
      sel_off();
      chk(VEC[i][33:32] == 2'b00 ? "R4 count" : VEC[i][33:32] == 2'b01 ? "R3 count" : "R2 count",
          rx_total - base, 1);
      chk(VEC[i][33:32] == 2'b00 ? "R4 word" : VEC[i][33:32] == 2'b01 ? "R3 word" : "R2 word",
          rx_mem[base % 16], VEC[i][31:0]);
    end

    // R5 gapless stream of 8-bit host words
    base = rx_total;
    sel_on(2'b00);
    send_word(2'b00, 32'h11223344);
    send_word(2'b00, 32'hCAFEF00D);
    send_word(2'b00, 32'h0F1E2D3C);
    sel_off();
    chk("R5 count", rx_total - base, 3);
    chk("R5 word0", rx_mem[base % 16], 32'h11223344);
    chk("R5 word1", rx_mem[(base + 1) % 16], 32'hCAFEF00D);
    chk("R5 word2", rx_mem[(base + 2) % 16], 32'h0F1E2D3C);

    // R6 width change while selected is ignored
    base = rx_total;
    sel_on(2'b01);
    send_host(32'h0000BEEF, 16);
    wsel = 2'b00;
    send_host(32'h00005A5A, 16);
    sel_off();
    chk("R6 count", rx_total - base, 1);
    chk("R6 word", rx_mem[base % 16], 32'h5A5ABEEF);

    // R7 abort discards partial bits
    base = rx_total;
    sel_on(2'b10);
    send_host(32'h00000FFF, 12);
    sel_off();
    sel_on(2'b10);
    send_word(2'b10, 32'h13572468);
    sel_off();
    chk("R7 count", rx_total - base, 1);
    chk("R7 word", rx_mem[base % 16], 32'h13572468);

    // R8 / R9 hold and overflow
    base = rx_total;
    ready = 1'b0;
    sel_on(2'b10);
    send_word(2'b10, 32'hAAAA5555);
    repeat (10) @(negedge clk);
    chk("R8 valid", {31'h0, wvalid}, 32'h1);
    chk("R8 data", wdata, 32'hAAAA5555);
    send_word(2'b10, 32'h0BADF00D);
    sel_off();
    chk("R8 data kept", wdata, 32'hAAAA5555);
    chk("R9 overflow", {31'h0, ovf}, 32'h1);
    ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 dropped", rx_total - base, 1);
    chk("R8 word", rx_mem[base % 16], 32'hAAAA5555);
    chk("R8 empty", {31'h0, wvalid}, 32'h0);
    chk("R9 sticky", {31'h0, ovf}, 32'h1);

    // R10 boot block, with reset clearing prior count (R1)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 overflow after reset", {31'h0, ovf}, 32'h0);
    base = rx_total;
    sel_on(2'b10);
    for (int n = 0; n < 383; n++) begin
      w = 32'h9E3779B9 * (n + 1);
      send_word(2'b10, w);
    end
    sel_off();
    chk("R10 count 383", rx_total - base, 383);
    chk("R10 not yet", {31'h0, done}, 32'h0);
    sel_on(2'b10);
    send_word(2'b10, 32'h00C0FFEE);
    sel_off();
    chk("R10 count 384", rx_total - base, 384);
    chk("R10 done", {31'h0, done}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule